// File: doc/BRIEF.md
# Three-Class Priority Packet Transmit Scheduler

This block sits in front of a link-layer transmitter. It takes outbound work from three descriptor queues, each a valid/ready port. The urgent queue carries acknowledgements. The normal queue carries either short messages or RDMA data packets. The background queue carries RDMA read requests. At each packet boundary the block chooses the most urgent queue that holds a descriptor. It formats that descriptor into header words on a registered word stream that carries start and end markers.

Acknowledgements and short messages carry their payload inside the descriptor, so each becomes one word. An RDMA request becomes a two-word header and involves no data fetch. An RDMA data packet becomes the same two-word header, followed by payload words taken from a DMA read stream. The number of payload words is the byte size rounded up to whole bus words. A packet runs to its end marker before any other queue is considered. If the DMA stream runs dry in the middle of a packet, the output goes invalid until data returns; no filler word is emitted.

Top module: `ptx_sched`

## Requirements
- R1: While `rst` is high, `out_valid` and all three queue readies are low.
- R2: When a packet starts, the urgent queue wins over the normal queue, and the normal queue wins over the background queue. Within a queue, descriptors leave in arrival order.
- R3: Once a packet's first word is loaded, no queue ready rises and no other packet's word appears until the word carrying `out_eop` has been sent.
- R4: An acknowledgement or short message is one word with both `out_sop` and `out_eop` set. Bits [63:62] hold the type (00 acknowledgement, 01 short message), [61:54] the source node, [53:46] the destination node, and [45:0] the embedded payload.
- R5: RDMA headers are two words. The first word has type in [63:62], local node in [61:54], remote node in [53:46], zeros in [45:16] and byte size in [15:0]. The second word has the source address in [63:32] and the destination address in [31:0].
- R6: An RDMA request has type 10 and ends on its second header word, whatever its size.
- R7: An RDMA data packet has type 11 and is followed by ceil(size/8) DMA words, passed through unchanged. `out_eop` is set on the last payload word, or on the second header word when the size is 0.
- R8: While a data packet waits for DMA words and `dma_valid` is low, no word is presented as valid and no queue is served.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sop` and `out_eop` stay unchanged.
- R10: At most one queue ready is high in any cycle. A queue ready is high only in the cycle in which that descriptor's first word is loaded into the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | Urgent queue holds a descriptor |
| ack_ready | output | 1 | Urgent descriptor taken |
| ack_src | input | 8 | Source node id |
| ack_dst | input | 8 | Destination node id |
| ack_pay | input | 46 | Embedded payload |
| mid_valid | input | 1 | Normal queue holds a descriptor |
| mid_ready | output | 1 | Normal descriptor taken |
| mid_is_rdma | input | 1 | 1: RDMA data packet, 0: short message |
| mid_src | input | 8 | Source / local node id |
| mid_dst | input | 8 | Destination / remote node id |
| mid_pay | input | 46 | Short message payload |
| mid_saddr | input | 32 | RDMA source address |
| mid_daddr | input | 32 | RDMA destination address |
| mid_size | input | 16 | RDMA byte size |
| req_valid | input | 1 | Background queue holds a descriptor |
| req_ready | output | 1 | Background descriptor taken |
| req_src | input | 8 | Local node id |
| req_dst | input | 8 | Remote node id |
| req_saddr | input | 32 | Source address |
| req_daddr | input | 32 | Destination address |
| req_size | input | 16 | Requested byte size |
| dma_valid | input | 1 | DMA payload word available |
| dma_ready | output | 1 | DMA payload word taken |
| dma_data | input | 64 | DMA payload word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Link transmitter accepts the word |
| out_data | output | 64 | Output word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |

## Verification
The embedded assertions check the cycle-level rules in every cycle: word holding under backpressure, a single queue ready at a time, priority among the queues at the moment one is served, no service during an open packet, and DMA words passing to the output unchanged. Word contents, header layouts, payload counts rounded up at the 0, 8, 9 and 20 byte sizes, the exact order of packets across the queues, and the stall during a DMA gap followed by resumption can only be shown by the bench scenarios. The bench compares every accepted word against a behavioural model of the packet sequence.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam logic [1:0] TY_ACK  = 2'b00;
  localparam logic [1:0] TY_MSG  = 2'b01;
  localparam logic [1:0] TY_REQ  = 2'b10;
  localparam logic [1:0] TY_RDMA = 2'b11;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HDR1 = 2'd1,
    S_PAY  = 2'd2
  } ptx_state_e;
endpackage

// File: rtl/ptx_arbiter.sv
module ptx_arbiter #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  // lowest index has the highest priority
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_top
      assign gnt[i] = req[0];
    end else begin : g_rest
      assign gnt[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign any = |req;
endmodule

// File: rtl/ptx_hdr_fmt.sv
module ptx_hdr_fmt
  import ptx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NODE_W = 8,
  parameter int SIZE_W = 16,
  localparam int PAY_W  = DATA_W - 2 - 2*NODE_W,
  localparam int ADDR_W = DATA_W / 2,
  localparam int BSH    = $clog2(DATA_W/8),
  localparam int CNT_W  = SIZE_W + 1 - BSH
) (
  input  logic [2:0]        gnt,
  input  logic [NODE_W-1:0] ack_src,
  input  logic [NODE_W-1:0] ack_dst,
  input  logic [PAY_W-1:0]  ack_pay,
  input  logic              mid_is_rdma,
  input  logic [NODE_W-1:0] mid_src,
  input  logic [NODE_W-1:0] mid_dst,
  input  logic [PAY_W-1:0]  mid_pay,
  input  logic [ADDR_W-1:0] mid_saddr,
  input  logic [ADDR_W-1:0] mid_daddr,
  input  logic [SIZE_W-1:0] mid_size,
  input  logic [NODE_W-1:0] req_src,
  input  logic [NODE_W-1:0] req_dst,
  input  logic [ADDR_W-1:0] req_saddr,
  input  logic [ADDR_W-1:0] req_daddr,
  input  logic [SIZE_W-1:0] req_size,
  output logic [DATA_W-1:0] word0,
  output logic [DATA_W-1:0] word1,
  output logic [CNT_W-1:0]  cnt,
  output logic              single
);
  localparam int PADW = DATA_W - 2 - 2*NODE_W - SIZE_W;

  function automatic logic [DATA_W-1:0] rdma_w0(input logic [1:0] ty,
      input logic [NODE_W-1:0] a, input logic [NODE_W-1:0] b,
      input logic [SIZE_W-1:0] sz);
    return {ty, a, b, {PADW{1'b0}}, sz};
  endfunction

  function automatic logic [CNT_W-1:0] words_of(input logic [SIZE_W-1:0] sz);
    logic [SIZE_W:0] r;
    r = {1'b0, sz} + (SIZE_W+1)'((DATA_W/8) - 1);
    return CNT_W'(r >> BSH);
  endfunction

  always_comb begin
    word0  = {TY_ACK, ack_src, ack_dst, ack_pay};
    word1  = '0;
    cnt    = '0;
    single = 1'b1;
    if (gnt[1]) begin
      if (mid_is_rdma) begin
        word0  = rdma_w0(TY_RDMA, mid_src, mid_dst, mid_size);
        word1  = {mid_saddr, mid_daddr};
        cnt    = words_of(mid_size);
        single = 1'b0;
      end else begin
        word0  = {TY_MSG, mid_src, mid_dst, mid_pay};
      end
    end else if (gnt[2]) begin
      word0  = rdma_w0(TY_REQ, req_src, req_dst, req_size);
      word1  = {req_saddr, req_daddr};
      single = 1'b0;
    end
  end
endmodule

// File: rtl/ptx_sched.sv
module ptx_sched
  import ptx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NODE_W = 8,
  parameter int SIZE_W = 16,
  localparam int PAY_W  = DATA_W - 2 - 2*NODE_W,
  localparam int ADDR_W = DATA_W / 2,
  localparam int CNT_W  = SIZE_W + 1 - $clog2(DATA_W/8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_valid,
  output logic              ack_ready,
  input  logic [NODE_W-1:0] ack_src,
  input  logic [NODE_W-1:0] ack_dst,
  input  logic [PAY_W-1:0]  ack_pay,
  input  logic              mid_valid,
  output logic              mid_ready,
  input  logic              mid_is_rdma,
  input  logic [NODE_W-1:0] mid_src,
  input  logic [NODE_W-1:0] mid_dst,
  input  logic [PAY_W-1:0]  mid_pay,
  input  logic [ADDR_W-1:0] mid_saddr,
  input  logic [ADDR_W-1:0] mid_daddr,
  input  logic [SIZE_W-1:0] mid_size,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NODE_W-1:0] req_src,
  input  logic [NODE_W-1:0] req_dst,
  input  logic [ADDR_W-1:0] req_saddr,
  input  logic [ADDR_W-1:0] req_daddr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic [DATA_W-1:0] dma_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  ptx_state_e        st;
  logic              o_valid, o_sop, o_eop;
  logic [DATA_W-1:0] o_data, w1_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        gnt;
  logic              any;
  logic [DATA_W-1:0] w0_n, w1_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              single_n;
  logic              can_load, pop;

  ptx_arbiter #(.N(3)) u_arb (
    .req ({req_valid, mid_valid, ack_valid}),
    .gnt (gnt),
    .any (any)
  );

  ptx_hdr_fmt #(.DATA_W(DATA_W), .NODE_W(NODE_W), .SIZE_W(SIZE_W)) u_fmt (
    .gnt(gnt),
    .ack_src(ack_src), .ack_dst(ack_dst), .ack_pay(ack_pay),
    .mid_is_rdma(mid_is_rdma), .mid_src(mid_src), .mid_dst(mid_dst),
    .mid_pay(mid_pay), .mid_saddr(mid_saddr), .mid_daddr(mid_daddr),
    .mid_size(mid_size),
    .req_src(req_src), .req_dst(req_dst), .req_saddr(req_saddr),
    .req_daddr(req_daddr), .req_size(req_size),
    .word0(w0_n), .word1(w1_n), .cnt(cnt_n), .single(single_n)
  );

  assign can_load  = !o_valid || out_ready;
  assign pop       = !rst && (st == S_IDLE) && can_load;
  assign ack_ready = pop && gnt[0];
  assign mid_ready = pop && gnt[1];
  assign req_ready = pop && gnt[2];
  assign dma_ready = !rst && (st == S_PAY) && can_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      o_valid <= 1'b0;
      o_sop   <= 1'b0;
      o_eop   <= 1'b0;
      o_data  <= '0;
      w1_q    <= '0;
      cnt_q   <= '0;
    end else if (can_load) begin
      o_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (any) begin
          o_valid <= 1'b1;
          o_data  <= w0_n;
          o_sop   <= 1'b1;
          o_eop   <= single_n;
          w1_q    <= w1_n;
          cnt_q   <= cnt_n;
          st      <= single_n ? S_IDLE : S_HDR1;
        end
        S_HDR1: begin
          o_valid <= 1'b1;
          o_data  <= w1_q;
          o_sop   <= 1'b0;
          o_eop   <= (cnt_q == '0);
          st      <= (cnt_q == '0) ? S_IDLE : S_PAY;
        end
        S_PAY: if (dma_valid) begin
          o_valid <= 1'b1;
          o_data  <= dma_data;
          o_sop   <= 1'b0;
          o_eop   <= (cnt_q == CNT_W'(1));
          cnt_q   <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign out_valid = o_valid;
  assign out_data  = o_data;
  assign out_sop   = o_sop;
  assign out_eop   = o_eop;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_sop) && $stable(out_eop)));

  // R10
  one_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_ready, mid_ready, req_ready}));

  // R10
  ready_loads_sop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_ready || mid_ready || req_ready) |=> (out_valid && out_sop));

  // R2
  mid_prio_chk: assert property (@(posedge clk) disable iff (rst)
    mid_ready |-> !ack_valid);

  // R2
  req_prio_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!ack_valid && !mid_valid));

  // R3
  no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |-> !(ack_ready || mid_ready || req_ready));

  // R7
  dma_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_valid && dma_ready) |=> (out_valid && !out_sop &&
                                  out_data == $past(dma_data)));

  // R8
  dma_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_ready && !dma_valid) |=> !out_valid);
endmodule

// File: tb/test_ptx_sched.sv
module test_ptx_sched;
  localparam int DATA_W = 64;
  localparam int NODE_W = 8;
  localparam int SIZE_W = 16;
  localparam int PAY_W  = 46;
  localparam int ADDR_W = 32;
  localparam logic [63:0] DMA_BASE = 64'hD000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // descriptor stores
  logic [7:0]  a_src [16];
  logic [7:0]  a_dst [16];
  logic [45:0] a_pay [16];
  logic        m_rd  [16];
  logic [7:0]  m_src [16];
  logic [7:0]  m_dst [16];
  logic [45:0] m_pay [16];
  logic [31:0] m_sa  [16];
  logic [31:0] m_da  [16];
  logic [15:0] m_sz  [16];
  logic [7:0]  r_src [16];
  logic [7:0]  r_dst [16];
  logic [31:0] r_sa  [16];
  logic [31:0] r_da  [16];
  logic [15:0] r_sz  [16];
  int ack_n = 0, mid_n = 0, req_n = 0;
  int ack_di = 0, mid_di = 0, req_di = 0;
  int dma_idx = 0;

  int rdy_mode = 0;
  logic dma_gate = 1'b1;
  int dma_mode = 0;

  logic ack_valid, ack_ready, mid_valid, mid_ready, req_valid, req_ready;
  logic dma_valid = 1'b0;
  logic dma_ready;
  logic out_ready = 1'b1;
  logic out_valid, out_sop, out_eop;
  logic [63:0] out_data, dma_data;

  assign ack_valid = ack_di < ack_n;
  assign mid_valid = mid_di < mid_n;
  assign req_valid = req_di < req_n;
  assign dma_data  = DMA_BASE + 64'(dma_idx);

  ptx_sched #(.DATA_W(DATA_W), .NODE_W(NODE_W), .SIZE_W(SIZE_W)) i_ptx_sched (
    .clk(clk), .rst(rst),
    .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_src(a_src[ack_di % 16]), .ack_dst(a_dst[ack_di % 16]), .ack_pay(a_pay[ack_di % 16]),
    .mid_valid(mid_valid), .mid_ready(mid_ready), .mid_is_rdma(m_rd[mid_di % 16]),
    .mid_src(m_src[mid_di % 16]), .mid_dst(m_dst[mid_di % 16]), .mid_pay(m_pay[mid_di % 16]),
    .mid_saddr(m_sa[mid_di % 16]), .mid_daddr(m_da[mid_di % 16]), .mid_size(m_sz[mid_di % 16]),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src(r_src[req_di % 16]), .req_dst(r_dst[req_di % 16]),
    .req_saddr(r_sa[req_di % 16]), .req_daddr(r_da[req_di % 16]), .req_size(r_sz[req_di % 16]),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_data(dma_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  // queue handshakes and link/DMA pacing, all by nonblocking update
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ack_valid && ack_ready) ack_di <= ack_di + 1;
    if (mid_valid && mid_ready) mid_di <= mid_di + 1;
    if (req_valid && req_ready) req_di <= req_di + 1;
    if (dma_valid && dma_ready) dma_idx <= dma_idx + 1;
    out_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 != 0) : 1'b0;
    dma_valid <= dma_gate && (dma_mode == 0 || cyc[0]);
  end

  // reference model: expected words of the current packet
  logic [63:0] exp_d[$];
  logic        exp_s[$];
  logic        exp_e[$];
  string       exp_t[$];
  int m_ack = 0, m_mid = 0, m_req = 0, m_dma = 0;

  function automatic void add(input logic [63:0] d, input logic s, input logic e,
                              input string t);
    exp_d.push_back(d); exp_s.push_back(s); exp_e.push_back(e); exp_t.push_back(t);
  endfunction

  function automatic void build_next();
    if (m_ack < ack_n) begin
      add({2'b00, a_src[m_ack], a_dst[m_ack], a_pay[m_ack]}, 1'b1, 1'b1, "R2/R4 ack");
      m_ack++;
    end else if (m_mid < mid_n) begin
      if (!m_rd[m_mid]) begin
        add({2'b01, m_src[m_mid], m_dst[m_mid], m_pay[m_mid]}, 1'b1, 1'b1, "R2/R4 msg");
      end else begin
        int nw;
        nw = (int'(m_sz[m_mid]) + 7) / 8;
        add({2'b11, m_src[m_mid], m_dst[m_mid], 30'd0, m_sz[m_mid]}, 1'b1, 1'b0, "R2/R5 wr0");
        add({m_sa[m_mid], m_da[m_mid]}, 1'b0, nw == 0, "R5/R7 wr1");
        for (int k = 0; k < nw; k++) begin
          add(DMA_BASE + 64'(m_dma), 1'b0, k == nw - 1, "R7 payload");
          m_dma++;
        end
      end
      m_mid++;
    end else if (m_req < req_n) begin
      add({2'b10, r_src[m_req], r_dst[m_req], 30'd0, r_sz[m_req]}, 1'b1, 1'b0, "R2/R6 rq0");
      add({r_sa[m_req], r_da[m_req]}, 1'b0, 1'b1, "R5/R6 rq1");
      m_req++;
    end
  endfunction

  logic        prev_hold = 1'b0;
  logic [63:0] prev_d;
  logic        prev_s, prev_e;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_hold) begin
        checks++;
        if (!(out_valid && out_data == prev_d && out_sop == prev_s && out_eop == prev_e)) begin
          errors++;
          $display("FAIL R9 hold: got v=%0b %h sop=%0b eop=%0b exp v=1 %h sop=%0b eop=%0b",
                   out_valid, out_data, out_sop, out_eop, prev_d, prev_s, prev_e);
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_d = out_data; prev_s = out_sop; prev_e = out_eop;
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) build_next();
        checks++;
        if (exp_d.size() == 0) begin
          errors++;
          $display("FAIL R3 unexpected word: got %h expected none", out_data);
        end else begin
          if (out_data !== exp_d[0] || out_sop !== exp_s[0] || out_eop !== exp_e[0]) begin
            errors++;
            $display("FAIL %s: got %h sop=%0b eop=%0b exp %h sop=%0b eop=%0b",
                     exp_t[0], out_data, out_sop, out_eop, exp_d[0], exp_s[0], exp_e[0]);
          end
          void'(exp_d.pop_front()); void'(exp_s.pop_front());
          void'(exp_e.pop_front()); void'(exp_t.pop_front());
        end
      end
    end
  end

  task automatic check(input bit ok, input string msg, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h exp %h", msg, got, exp);
    end
  endtask

  task automatic push_ack(input logic [7:0] s, input logic [7:0] d, input logic [45:0] p);
    a_src[ack_n] = s; a_dst[ack_n] = d; a_pay[ack_n] = p; ack_n++;
  endtask

  task automatic push_mid(input logic rd, input logic [7:0] s, input logic [7:0] d,
                          input logic [45:0] p, input logic [31:0] sa,
                          input logic [31:0] da, input logic [15:0] sz);
    m_rd[mid_n] = rd; m_src[mid_n] = s; m_dst[mid_n] = d; m_pay[mid_n] = p;
    m_sa[mid_n] = sa; m_da[mid_n] = da; m_sz[mid_n] = sz; mid_n++;
  endtask

  task automatic push_req(input logic [7:0] s, input logic [7:0] d, input logic [31:0] sa,
                          input logic [31:0] da, input logic [15:0] sz);
    r_src[req_n] = s; r_dst[req_n] = d; r_sa[req_n] = sa; r_da[req_n] = da;
    r_sz[req_n] = sz; req_n++;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (!(m_ack == ack_n && m_mid == mid_n && m_req == req_n &&
             exp_d.size() == 0 && !out_valid) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(t < 3000, "R2 drain of queued packets", 64'(t), 64'(3000));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state with work waiting
    push_ack(8'h01, 8'h02, 46'h1);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    check({ack_ready, mid_ready, req_ready} == 3'b000, "R1 readies in reset",
          64'({ack_ready, mid_ready, req_ready}), 64'd0);
    rst = 1'b0;
    drain();

    // S1: mixed classes queued together, free-running link and DMA
    @(negedge clk);
    push_req(8'h10, 8'h11, 32'hA000_0000, 32'hB000_0000, 16'd8);
    push_mid(1'b0, 8'h20, 8'h21, 46'h2AAA_5555_1234, 32'h0, 32'h0, 16'd0);
    push_ack(8'h30, 8'h31, 46'h0_0000_ABCD);
    push_mid(1'b1, 8'h40, 8'h41, 46'h0, 32'h1111_0000, 32'h2222_0000, 16'd20);
    push_ack(8'h32, 8'h33, 46'h3FFF_FFFF_FFFF);
    push_mid(1'b1, 8'h42, 8'h43, 46'h0, 32'h1111_0100, 32'h2222_0100, 16'd0);
    push_req(8'h12, 8'h13, 32'hA000_0040, 32'hB000_0040, 16'd9);
    drain();

    // S2: link backpressure and gappy DMA, sizes 9 and 8 and 40
    rdy_mode = 1; dma_mode = 1;
    @(negedge clk);
    push_mid(1'b1, 8'h50, 8'h51, 46'h0, 32'h3333_0000, 32'h4444_0000, 16'd9);
    push_mid(1'b1, 8'h52, 8'h53, 46'h0, 32'h3333_0200, 32'h4444_0200, 16'd8);
    push_ack(8'h60, 8'h61, 46'h1_2345_6789);
    push_req(8'h70, 8'h71, 32'h5555_0000, 32'h6666_0000, 16'd40);
    push_mid(1'b0, 8'h54, 8'h55, 46'h0_00FF_00FF, 32'h0, 32'h0, 16'd0);
    drain();

    // S3: DMA dries up mid-packet, urgent work arrives during the gap
    rdy_mode = 0; dma_mode = 0; dma_gate = 1'b0;
    @(negedge clk);
    push_mid(1'b1, 8'h80, 8'h81, 46'h0, 32'h7777_0000, 32'h8888_0000, 16'd64);
    repeat (12) @(negedge clk);
    check(out_valid == 1'b0, "R8 no valid word during DMA gap", 64'(out_valid), 64'd0);
    push_ack(8'h90, 8'h91, 46'h0_0000_0777);
    push_req(8'h92, 8'h93, 32'h9999_0000, 32'hAAAA_0000, 16'd4);
    repeat (6) @(negedge clk);
    check(out_valid == 1'b0, "R3 no other packet while one is open", 64'(out_valid), 64'd0);
    check({ack_ready, req_ready} == 2'b00, "R3 queues not served while open",
          64'({ack_ready, req_ready}), 64'd0);
    dma_gate = 1'b1;
    drain();

    // S4: link stalled with a word held, more work queued behind it
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    push_ack(8'hA0, 8'hA1, 46'h0_0000_0042);
    repeat (3) @(negedge clk);
    push_ack(8'hA2, 8'hA3, 46'h0_0000_0043);
    push_mid(1'b0, 8'hA4, 8'hA5, 46'h0_0000_0044, 32'h0, 32'h0, 16'd0);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b1 && out_data == {2'b00, 8'hA0, 8'hA1, 46'h0_0000_0042},
          "R9 first word held while link stalled", out_data,
          {2'b00, 8'hA0, 8'hA1, 46'h0_0000_0042});
    check({ack_ready, mid_ready} == 2'b00, "R10 no queue served while output full",
          64'({ack_ready, mid_ready}), 64'd0);
    rdy_mode = 0;
    drain();

    check(ack_di == ack_n && mid_di == mid_n && req_di == req_n,
          "R10 every descriptor taken exactly once", 64'(ack_di + mid_di + req_di),
          64'(ack_n + mid_n + req_n));
    check(dma_idx == m_dma, "R7 DMA words consumed match rounded sizes",
          64'(dma_idx), 64'(m_dma));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule